// File: doc/BRIEF.md
# External Interrupt and Wakeup Controller

This block watches four external interrupt pins and two internal event sources, a brown-out event and a real-time-clock event. Each pin passes through a two-flop synchronizer and is then detected as either a high level or a rising edge, chosen per pin by a mode register. A detected event latches a per-pin flag, and the flags drive the interrupt request lines towards a vectored interrupt controller. Software clears a flag by writing a one to its bit.

Wakeup is independent of interrupt enabling. A wake-enable register chooses which sources may raise a single wake request while the power-down status input is high. An external pin can wake the core only if the pin multiplexer has selected its interrupt function and its own flag is still clear. Once raised, the wake request stays high until power-down ends. A small register bus reaches the three registers. Read data is registered and follows the address by one clock.

Top module: `ext_irq_wake`

## Requirements
- R1: After a synchronous reset, the flag, mode and wake-enable registers are zero, `irq_o` is 0, `wake_o` is 0 and `bus_rdata_o` is 0.
- R2: Register addresses are 0 = flags, 1 = mode, 2 = wake-enable. Address 3 reads 0. In wake-enable, bits 0..3 enable pins 0..3, bit 14 enables the brown-out source and bit 15 enables the real-time-clock source. Bits 13:4 ignore writes and read 0. `bus_rdata_o` shows the addressed register one clock after the address is presented.
- R3: With mode bit 1 (edge), a rising edge on a selected pin sets its flag. `irq_o` shows the flag on the third rising clock after the pin changes.
- R4: With mode bit 0 (level), a high selected pin sets its flag. The flag stays set while the pin is high, even when a one is written to clear it.
- R5: Writing 1 to bit i of the flag register clears flag i on the next clock. Writing 0 to a bit leaves that flag unchanged.
- R6: A pin whose `func_sel_i` bit is 0 never sets its flag and never causes a wake.
- R7: While `pwr_down_i` is high, a selected pin whose wake-enable bit is 1 raises `wake_o` in the same clock in which its flag would be set. A pin whose wake-enable bit is 0 never raises `wake_o`, even when it interrupts.
- R8: A pin event does not raise `wake_o` while that pin's flag is already set.
- R9: `wake_o` is never high unless `pwr_down_i` was high at the previous clock. Once high, it stays high until `pwr_down_i` goes low.
- R10: A high `bod_evt_i` with wake-enable bit 14 set, or a high `rtc_evt_i` with bit 15 set, raises `wake_o` one clock later while in power-down. With the bit clear, the event has no effect.
- R11: Changing a pin's mode from edge to level while the pin is high sets its flag. After the pin goes low, a one written to the flag clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 4 | Asynchronous external interrupt pins |
| func_sel_i | input | 4 | Pin has its interrupt function selected |
| bod_evt_i | input | 1 | Brown-out event, synchronous |
| rtc_evt_i | input | 1 | Real-time-clock event, synchronous |
| pwr_down_i | input | 1 | Core is in power-down |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| irq_o | output | 4 | Interrupt requests, one per pin |
| wake_o | output | 1 | Wake request |

## Verification
The bench checks that a level-mode flag survives a clear while the pin is still high. A design that lets the clear win would drop a pending interrupt. It also checks that a pin with a set flag cannot wake the core, and that an interrupting pin with its wake bit clear leaves power-down alone. A wrong gate there would produce spurious wakeups. Reserved wake-enable bits are written with ones and read back, which exposes a register that stores them. A mode switch with the pin held high, together with a long pseudo-random run compared against a behavioural model, exposes off-by-one pipeline timing and wake requests that are not held until power-down ends.

// File: rtl/eiw_pkg.sv
package eiw_pkg;
  localparam int REG_AW = 2;
  localparam int REG_DW = 16;
  localparam logic [REG_AW-1:0] ADDR_FLAG = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_MODE = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_WAKE = 2'd2;
  localparam int BOD_BIT = 14;
  localparam int RTC_BIT = 15;

  typedef enum logic {
    DET_LEVEL = 1'b0,
    DET_EDGE  = 1'b1
  } det_mode_e;

  function automatic logic [REG_DW-1:0] wake_mask(input int pins);
    logic [REG_DW-1:0] m;
    m = '0;
    for (int k = 0; k < pins; k++) m[k] = 1'b1;
    m[BOD_BIT] = 1'b1;
    m[RTC_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/eiw_sync.sv
module eiw_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
      prev_q <= '0;
    end else begin
      chain[0] <= d_i;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      prev_q <= chain[STAGES-1];
    end
  end

  assign q_o    = chain[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/eiw_detect.sv
module eiw_detect
  import eiw_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] mode_i,
  input  logic [W-1:0] sel_i,
  output logic [W-1:0] det_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic hit;
    always_comb begin
      if (det_mode_e'(mode_i[i]) == DET_EDGE) hit = lvl_i[i] & ~prev_i[i];
      else                                    hit = lvl_i[i];
    end
    assign det_o[i] = sel_i[i] & hit;
  end
endmodule

// File: rtl/eiw_flags.sv
module eiw_flags #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] det_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           flag_q[i] <= 1'b0;
      else if (det_i[i]) flag_q[i] <= 1'b1;
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/eiw_wake.sv
module eiw_wake #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] det_i,
  input  logic [W-1:0] flag_i,
  input  logic [W-1:0] pin_en_i,
  input  logic         bod_i,
  input  logic         bod_en_i,
  input  logic         rtc_i,
  input  logic         rtc_en_i,
  input  logic         pd_i,
  output logic         wake_o
);
  logic [W-1:0] pin_src;
  logic         any_src;
  logic         wake_q;

  for (genvar i = 0; i < W; i++) begin : g_src
    assign pin_src[i] = pin_en_i[i] & det_i[i] & ~flag_i[i];
  end

  assign any_src = (|pin_src) | (bod_i & bod_en_i) | (rtc_i & rtc_en_i);

  always_ff @(posedge clk) begin
    if (rst) wake_q <= 1'b0;
    else     wake_q <= pd_i & (wake_q | any_src);
  end

  assign wake_o = wake_q;
endmodule

// File: rtl/ext_irq_wake.sv
module ext_irq_wake
  import eiw_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] func_sel_i,
  input  logic                bod_evt_i,
  input  logic                rtc_evt_i,
  input  logic                pwr_down_i,
  input  logic                bus_wr_i,
  input  logic [REG_AW-1:0]   bus_addr_i,
  input  logic [REG_DW-1:0]   bus_wdata_i,
  output logic [REG_DW-1:0]   bus_rdata_o,
  output logic [NUM_PINS-1:0] irq_o,
  output logic                wake_o
);
  localparam logic [REG_DW-1:0] WEN_MASK = wake_mask(NUM_PINS);

  logic [NUM_PINS-1:0] lvl, prev, det, flags, clr;
  logic [NUM_PINS-1:0] mode_q;
  logic [REG_DW-1:0]   wen_q;
  logic [REG_DW-1:0]   rdata_q;
  logic                wr_flag, wr_mode, wr_wake;

  assign wr_flag = bus_wr_i && (bus_addr_i == ADDR_FLAG);
  assign wr_mode = bus_wr_i && (bus_addr_i == ADDR_MODE);
  assign wr_wake = bus_wr_i && (bus_addr_i == ADDR_WAKE);
  assign clr     = wr_flag ? bus_wdata_i[NUM_PINS-1:0] : '0;

  eiw_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(lvl), .prev_o(prev)
  );

  eiw_detect #(.W(NUM_PINS)) u_det (
    .lvl_i(lvl), .prev_i(prev), .mode_i(mode_q), .sel_i(func_sel_i), .det_o(det)
  );

  eiw_flags #(.W(NUM_PINS)) u_flags (
    .clk(clk), .rst(rst), .det_i(det), .clr_i(clr), .flag_o(flags)
  );

  eiw_wake #(.W(NUM_PINS)) u_wake (
    .clk(clk), .rst(rst), .det_i(det), .flag_i(flags),
    .pin_en_i(wen_q[NUM_PINS-1:0]),
    .bod_i(bod_evt_i), .bod_en_i(wen_q[BOD_BIT]),
    .rtc_i(rtc_evt_i), .rtc_en_i(wen_q[RTC_BIT]),
    .pd_i(pwr_down_i), .wake_o(wake_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      wen_q  <= '0;
    end else begin
      if (wr_mode) mode_q <= bus_wdata_i[NUM_PINS-1:0];
      if (wr_wake) wen_q  <= bus_wdata_i & WEN_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      unique case (bus_addr_i)
        ADDR_FLAG: rdata_q <= REG_DW'(flags);
        ADDR_MODE: rdata_q <= REG_DW'(mode_q);
        ADDR_WAKE: rdata_q <= wen_q;
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = flags;
endmodule

// File: rtl/eiw_checker.sv
module eiw_checker
  import eiw_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                pwr_down_i,
  input logic                wake_o,
  input logic [REG_AW-1:0]   bus_addr_i,
  input logic [REG_DW-1:0]   bus_rdata_o,
  input logic [NUM_PINS-1:0] irq_o,
  input logic [NUM_PINS-1:0] func_sel_i,
  input logic [REG_DW-1:0]   wen_q
);
  assert_wake_needs_pd_R9: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(pwr_down_i));

  assert_wake_held_R9: assert property (@(posedge clk) disable iff (rst)
    (wake_o && pwr_down_i) |=> wake_o);

  assert_wake_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_o) |-> $past(wen_q != '0));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_addr_i == ADDR_WAKE) |=> (bus_rdata_o[BOD_BIT-1:NUM_PINS] == '0));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_sel
    assert_irq_needs_sel_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_o[i]) |-> $past(func_sel_i[i]));
  end
endmodule

bind ext_irq_wake eiw_checker #(.NUM_PINS(NUM_PINS)) u_eiw_checker (
  .clk(clk), .rst(rst), .pwr_down_i(pwr_down_i), .wake_o(wake_o),
  .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o),
  .func_sel_i(func_sel_i), .wen_q(wen_q)
);

// File: tb/test_ext_irq_wake.sv
module test_ext_irq_wake;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  pin_i = '0, func_sel_i = '0;
  logic        bod_evt_i = 1'b0, rtc_evt_i = 1'b0, pwr_down_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic [3:0]  irq_o;
  logic        wake_o;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  ext_irq_wake i_ext_irq_wake (
    .clk(clk), .rst(rst), .pin_i(pin_i), .func_sel_i(func_sel_i),
    .bod_evt_i(bod_evt_i), .rtc_evt_i(rtc_evt_i), .pwr_down_i(pwr_down_i),
    .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  // Behavioural reference: pin history queue per pin, plain bits for state.
  bit m_flag [4];
  bit m_mode [4];
  bit [15:0] m_wen;
  bit [15:0] m_rdata;
  bit m_wake;
  bit hist [4][3];

  always @(posedge clk) begin
    bit det [4];
    bit any;
    bit [3:0] fl;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        m_flag[i] = 0; m_mode[i] = 0;
        for (int j = 0; j < 3; j++) hist[i][j] = 0;
      end
      m_wen = 0; m_rdata = 0; m_wake = 0;
    end else begin
      any = (bod_evt_i && m_wen[14]) || (rtc_evt_i && m_wen[15]);
      for (int i = 0; i < 4; i++) begin
        if (!func_sel_i[i]) det[i] = 0;
        else if (m_mode[i]) det[i] = hist[i][1] && !hist[i][2];
        else det[i] = hist[i][1];
        if (m_wen[i] && det[i] && !m_flag[i]) any = 1;
        fl[i] = m_flag[i];
      end
      case (bus_addr_i)
        2'd0: m_rdata = {12'd0, fl};
        2'd1: m_rdata = {12'd0, m_mode[3], m_mode[2], m_mode[1], m_mode[0]};
        2'd2: m_rdata = m_wen;
        default: m_rdata = 0;
      endcase
      m_wake = pwr_down_i && (m_wake || any);
      for (int i = 0; i < 4; i++) begin
        if (det[i]) m_flag[i] = 1;
        else if (bus_wr_i && bus_addr_i == 2'd0 && bus_wdata_i[i]) m_flag[i] = 0;
        if (bus_wr_i && bus_addr_i == 2'd1) m_mode[i] = bus_wdata_i[i];
        hist[i][2] = hist[i][1];
        hist[i][1] = hist[i][0];
        hist[i][0] = pin_i[i];
      end
      if (bus_wr_i && bus_addr_i == 2'd2) m_wen = bus_wdata_i & 16'hC00F;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, away from the edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(irq_o == {m_flag[3], m_flag[2], m_flag[1], m_flag[0]}, cur_req,
          {12'd0, irq_o}, {12'd0, m_flag[3], m_flag[2], m_flag[1], m_flag[0]});
      chk(wake_o == m_wake, cur_req, {15'd0, wake_o}, {15'd0, m_wake});
      chk(bus_rdata_o == m_rdata, cur_req, bus_rdata_o, m_rdata);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d;
    step(1);
    bus_wr_i = 0; bus_wdata_i = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr_i = a;
    step(1);
    d = bus_rdata_o;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [15:0] lfsr;
    step(3);
    rst = 0;
    step(1);
    cur_req = "R1";
    chk(irq_o == 0 && wake_o == 0 && bus_rdata_o == 0, "R1", {irq_o, 11'd0, wake_o}, 16'h0);
    rd(2'd1, d); chk(d == 0, "R1", d, 0);
    rd(2'd2, d); chk(d == 0, "R1", d, 0);

    cur_req = "R2";
    wr(2'd2, 16'hFFFF);
    rd(2'd2, d); chk(d == 16'hC00F, "R2", d, 16'hC00F);
    rd(2'd3, d); chk(d == 0, "R2", d, 0);
    wr(2'd2, 16'h0000);

    cur_req = "R3";
    func_sel_i = 4'hF;
    wr(2'd1, 16'h0001);
    pin_i[0] = 1;
    step(2); chk(irq_o[0] == 0, "R3", {15'd0, irq_o[0]}, 0);
    step(1); chk(irq_o[0] == 1, "R3", {15'd0, irq_o[0]}, 1);

    cur_req = "R5";
    wr(2'd0, 16'h000E);
    chk(irq_o[0] == 1, "R5", {15'd0, irq_o[0]}, 1);
    wr(2'd0, 16'h0001);
    chk(irq_o[0] == 0, "R5", {15'd0, irq_o[0]}, 0);
    pin_i[0] = 0; step(4);

    cur_req = "R4";
    pin_i[1] = 1; step(3);
    chk(irq_o[1] == 1, "R4", {15'd0, irq_o[1]}, 1);
    wr(2'd0, 16'h0002); step(1);
    chk(irq_o[1] == 1, "R4", {15'd0, irq_o[1]}, 1);
    pin_i[1] = 0; step(3);
    wr(2'd0, 16'h0002);
    chk(irq_o[1] == 0, "R4", {15'd0, irq_o[1]}, 0);

    cur_req = "R6";
    func_sel_i[2] = 0; pwr_down_i = 1;
    wr(2'd2, 16'h0004);
    pin_i[2] = 1; step(4);
    chk(irq_o[2] == 0 && wake_o == 0, "R6", {irq_o, 11'd0, wake_o}, 0);
    pin_i[2] = 0; func_sel_i[2] = 1; pwr_down_i = 0; step(3);

    cur_req = "R7";
    wr(2'd2, 16'h0000);
    pwr_down_i = 1;
    pin_i[3] = 1; step(4);
    chk(irq_o[3] == 1 && wake_o == 0, "R7", {irq_o, 11'd0, wake_o}, 16'h8000);
    pin_i[3] = 0; step(3); wr(2'd0, 16'h0008);
    wr(2'd2, 16'h0001);
    pin_i[0] = 1; step(2);
    chk(wake_o == 0, "R7", {15'd0, wake_o}, 0);
    step(1);
    chk(wake_o == 1, "R7", {15'd0, wake_o}, 1);

    cur_req = "R9";
    pin_i[0] = 0; step(5);
    chk(wake_o == 1, "R9", {15'd0, wake_o}, 1);
    pwr_down_i = 0; step(1);
    chk(wake_o == 0, "R9", {15'd0, wake_o}, 0);

    cur_req = "R8";
    pwr_down_i = 1;
    pin_i[0] = 1; step(5);
    chk(wake_o == 0, "R8", {15'd0, wake_o}, 0);
    pin_i[0] = 0; pwr_down_i = 0; step(3);
    wr(2'd0, 16'h000F);

    cur_req = "R10";
    pwr_down_i = 1;
    bod_evt_i = 1; step(1); bod_evt_i = 0; step(1);
    chk(wake_o == 0, "R10", {15'd0, wake_o}, 0);
    wr(2'd2, 16'h4000);
    bod_evt_i = 1; step(1); bod_evt_i = 0;
    chk(wake_o == 1, "R10", {15'd0, wake_o}, 1);
    pwr_down_i = 0; step(1); pwr_down_i = 1;
    wr(2'd2, 16'h8000);
    rtc_evt_i = 1; step(1); rtc_evt_i = 0;
    chk(wake_o == 1, "R10", {15'd0, wake_o}, 1);
    pwr_down_i = 0; step(1);

    cur_req = "R11";
    wr(2'd1, 16'h0004);
    pin_i[2] = 1; step(4);
    wr(2'd0, 16'h0004); step(1);
    chk(irq_o[2] == 0, "R11", {15'd0, irq_o[2]}, 0);
    wr(2'd1, 16'h0000); step(1);
    chk(irq_o[2] == 1, "R11", {15'd0, irq_o[2]}, 1);
    pin_i[2] = 0; step(3);
    wr(2'd0, 16'h0004);
    chk(irq_o[2] == 0, "R11", {15'd0, irq_o[2]}, 0);

    cur_req = "R5";
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pin_i = lfsr[3:0] ^ lfsr[11:8];
      if (lfsr[7:5] == 0) func_sel_i = lfsr[15:12];
      pwr_down_i = lfsr[14] | lfsr[9];
      bod_evt_i = (lfsr[6:4] == 3'd5);
      rtc_evt_i = (lfsr[6:4] == 3'd2);
      bus_addr_i = lfsr[12:11];
      bus_wr_i = (lfsr[10:8] == 3'd3);
      bus_wdata_i = {lfsr[0], lfsr[1], lfsr[15:2]};
      step(1);
    end
    bus_wr_i = 0;
    step(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule